// File: doc/BRIEF.md
# Freeze-on-Error Event History Buffer

This block sits next to an interface protocol checker. Every cycle the checker marks as monitored, the block keeps a compact record of the event the checker matched: a small table index and one bit saying whether the observed pattern was found in the table at all. The records go into a circular store that keeps only the most recent `DEPTH` of them. Older records are overwritten without notice.

When the checker raises its error strobe, capture stops. The record for that same cycle is still stored, so the newest record always shows the failing event. From the next cycle on, the block streams the held records through a valid/ready port. The oldest record comes out first, and the newest is tagged with a last marker. While capture is running, the port stays silent. Once the whole history has been handed over, a re-arm pulse empties the store and capture starts again.

Top module: `evt_history_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `frozen`, `outValid` and `outLast` are 0 and the store is empty.
- R2: While capturing (`frozen` = 0), `outValid` stays 0.
- R3: When `errFlag` is 1 during capture, `frozen` is 1 from the next cycle on. If `sampleEn` was also 1 in that cycle, its record is written and is the last one read out.
- R4: If fewer than `DEPTH` records were taken since the last re-arm or reset, the readout presents exactly those records, in the order they were written, starting with the first.
- R5: If `DEPTH` or more records were taken, the readout presents exactly `DEPTH` records: the most recent ones, oldest first.
- R6: Each record read out gives back both the index on `outIdx` and the known bit on `outKnown`, as they were sampled.
- R7: While `outValid` = 1 and `outReady` = 0, `outValid`, `outIdx`, `outKnown` and `outLast` hold their values into the next cycle.
- R8: `outLast` is 1 only together with `outValid`, and only on the newest record. After that record is accepted, `outValid` falls to 0.
- R9: While frozen, `sampleEn` and `errFlag` have no effect on the records that are read out.
- R10: `rearm` takes effect only when frozen with the readout finished. It is ignored during capture and during readout, including on the cycle the newest record is accepted. Once accepted, it empties the store and `frozen` is 0 on the next cycle.
- R11: An error during capture with nothing stored and `sampleEn` = 0 freezes the block with no readout: `outValid` stays 0.
- R12: Cycles with `sampleEn` = 0 leave no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | The current cycle is monitored and its record is stored |
| evtIdx | input | IDX_W | Event table index from the checker |
| evtKnown | input | 1 | 1 if the observed pattern matched a table entry |
| errFlag | input | 1 | Checker mismatch; freezes the history |
| rearm | input | 1 | Clear the store and resume capture once the readout is done |
| outReady | input | 1 | Off-chip side accepts the presented record |
| outValid | output | 1 | A held record is presented |
| outIdx | output | IDX_W | Index of the presented record |
| outKnown | output | 1 | Known bit of the presented record |
| outLast | output | 1 | The presented record is the newest one |
| frozen | output | 1 | Capture is stopped |

## Verification
Two pairs of events can land in the same cycle. The first pair is the error and the final write: each capture run ends with `errFlag` and `sampleEn` asserted together. The readout must then end with that same record under `outLast`, and this is checked for several histories: short, exactly full, one past full, and wrapped many times. The second pair is the re-arm and the acceptance of the newest record. The bench raises `rearm` on exactly the cycle the last handshake completes, then checks that `frozen` stays 1 and that `outValid` has dropped. A later, separate re-arm must bring `frozen` back to 0.

// File: rtl/ehb_pkg.sv
package ehb_pkg;
  typedef enum logic [1:0] {
    ST_CAPTURE = 2'd0,
    ST_READ    = 2'd1,
    ST_DONE    = 2'd2
  } ehbState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;       // store the current record at the write pointer
    logic clrPtr;     // return the write pointer to slot 0
    logic loadRd;     // load the read pointer with the oldest slot
    logic fromWrPtr;  // oldest slot is the post-write write pointer (wrapped)
    logic advRd;      // step the read pointer
  } ehbStrobe_t;
endpackage

// File: rtl/ehb_ctrl.sv
module ehb_ctrl
  import ehb_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       errFlag,
  input  logic       rearm,
  input  logic       outReady,
  output ehbStrobe_t strobe,
  output logic       outValid,
  output logic       outLast,
  output logic       frozen
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  ehbState_e state, nextState;
  logic [CNT_W-1:0] fillCnt, fillAfter;
  logic [CNT_W-1:0] readCnt;
  logic isNewest;

  assign isNewest = (CNT_W'(readCnt + 1'b1) == fillCnt);

  always_comb begin
    strobe    = '0;
    nextState = state;
    fillAfter = fillCnt;
    unique case (state)
      ST_CAPTURE: begin
        strobe.wrEn = sampleEn;
        if (sampleEn && fillCnt != DEPTH_C) fillAfter = CNT_W'(fillCnt + 1'b1);
        if (errFlag) begin
          if (fillAfter == '0) begin
            nextState = ST_DONE;
          end else begin
            nextState        = ST_READ;
            strobe.loadRd    = 1'b1;
            strobe.fromWrPtr = (fillAfter == DEPTH_C);
          end
        end
      end
      ST_READ: begin
        strobe.advRd = outReady;
        if (outReady && isNewest) nextState = ST_DONE;
      end
      ST_DONE: begin
        if (rearm) begin
          strobe.clrPtr = 1'b1;
          nextState     = ST_CAPTURE;
        end
      end
      default: nextState = ST_CAPTURE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CAPTURE;
      fillCnt <= '0;
      readCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_CAPTURE) fillCnt <= fillAfter;
      else if (strobe.clrPtr)  fillCnt <= '0;
      if (strobe.loadRd)      readCnt <= '0;
      else if (strobe.advRd)  readCnt <= CNT_W'(readCnt + 1'b1);
    end
  end

  assign outValid = (state == ST_READ);
  assign outLast  = (state == ST_READ) && isNewest;
  assign frozen   = (state != ST_CAPTURE);
endmodule

// File: rtl/ehb_data.sv
module ehb_data
  import ehb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ENT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ehbStrobe_t       strobe,
  input  logic [ENT_W-1:0] wrEntry,
  output logic [ENT_W-1:0] rdEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrAfter;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  assign wrPtrAfter = strobe.wrEn ? stepPtr(wrPtr) : wrPtr;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.clrPtr) wrPtr <= '0;
      else               wrPtr <= wrPtrAfter;
      if (strobe.loadRd)     rdPtr <= strobe.fromWrPtr ? wrPtrAfter : '0;
      else if (strobe.advRd) rdPtr <= stepPtr(rdPtr);
    end
  end

  assign rdEntry = store[rdPtr];
endmodule

// File: rtl/evt_history_buf.sv
module evt_history_buf
  import ehb_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic [IDX_W-1:0] evtIdx,
  input  logic             evtKnown,
  input  logic             errFlag,
  input  logic             rearm,
  input  logic             outReady,
  output logic             outValid,
  output logic [IDX_W-1:0] outIdx,
  output logic             outKnown,
  output logic             outLast,
  output logic             frozen
);
  localparam int ENT_W = IDX_W + 1;

  ehbStrobe_t       strobe;
  logic [ENT_W-1:0] rdEntry;

  ehb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .errFlag(errFlag),
    .rearm(rearm), .outReady(outReady), .strobe(strobe),
    .outValid(outValid), .outLast(outLast), .frozen(frozen)
  );

  ehb_data #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrEntry({evtKnown, evtIdx}), .rdEntry(rdEntry)
  );

  assign outIdx   = rdEntry[IDX_W-1:0];
  assign outKnown = rdEntry[IDX_W];
endmodule

// File: rtl/ehb_checker.sv
module ehb_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             errFlag,
  input logic             rearm,
  input logic             outReady,
  input logic             outValid,
  input logic [IDX_W-1:0] outIdx,
  input logic             outKnown,
  input logic             outLast,
  input logic             frozen
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!frozen && !outValid && !outLast));

  // R2
  a_r2_quiet_capture: assert property (@(posedge clk) disable iff (!rstN)
    !frozen |-> !outValid);

  // R3
  a_r3_error_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && errFlag) |=> frozen);

  // R7
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outIdx) && $stable(outKnown)
                                 && $stable(outLast)));

  // R8
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8
  a_r8_drop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady) |=> !outValid);

  // R10
  a_r10_rearm_ignored_reading: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rearm) |=> frozen);
endmodule

bind evt_history_buf ehb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .errFlag(errFlag), .rearm(rearm), .outReady(outReady),
  .outValid(outValid), .outIdx(outIdx), .outKnown(outKnown), .outLast(outLast),
  .frozen(frozen)
);

// File: tb/evt_history_buf_tb.sv
module evt_history_buf_tb;
  localparam int IDX_W = 5;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0, evtKnown = 1'b0, errFlag = 1'b0, rearm = 1'b0, outReady = 1'b0;
  logic [IDX_W-1:0] evtIdx = '0;
  logic outValid, outKnown, outLast, frozen;
  logic [IDX_W-1:0] outIdx;

  int nChecks = 0;
  int nFail = 0;
  logic [IDX_W:0] model[$];

  always #10 clk = ~clk;

  evt_history_buf #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .evtIdx(evtIdx),
    .evtKnown(evtKnown), .errFlag(errFlag), .rearm(rearm), .outReady(outReady),
    .outValid(outValid), .outIdx(outIdx), .outKnown(outKnown), .outLast(outLast),
    .frozen(frozen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  // Run n capture cycles; optionally end with error plus sample in the same cycle.
  task automatic capture(input int n, input int pct, input bit endErr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R2 no output while capturing", int'(outValid), 0);
      chk(frozen == 1'b0, "R2 not frozen while capturing", int'(frozen), 0);
      sampleEn = pick(pct) || (endErr && i == n - 1);   // R12: unsampled cycles
      evtIdx   = IDX_W'($urandom);
      evtKnown = 1'($urandom);
      errFlag  = endErr && (i == n - 1);
      rearm    = pick(25);                              // R10: ignored while capturing
      if (sampleEn) begin
        model.push_back({evtKnown, evtIdx});
        if (model.size() > DEPTH) void'(model.pop_front());
      end
    end
    @(negedge clk);
    sampleEn = 1'b0; errFlag = 1'b0; rearm = 1'b0;
    chk(frozen == 1'b1, "R3 frozen after error", int'(frozen), 1);
  endtask

  // Drain the readout and compare with the model; noise on capture inputs (R9).
  task automatic drain(input string tag, input bit rearmOnLast);
    while (model.size() > 0) begin
      chk(outValid == 1'b1, {tag, " valid during readout"}, int'(outValid), 1);
      chk(outIdx == model[0][IDX_W-1:0], {tag, " index order"}, int'(outIdx),
          int'(model[0][IDX_W-1:0]));
      chk(outKnown == model[0][IDX_W], "R6 known bit", int'(outKnown), int'(model[0][IDX_W]));
      chk(outLast == (model.size() == 1), "R8 last marker", int'(outLast),
          int'(model.size() == 1));
      outReady = pick(60);
      sampleEn = pick(50);
      errFlag  = pick(20);
      evtIdx   = IDX_W'($urandom);
      rearm    = rearmOnLast && outReady && (model.size() == 1);
      @(negedge clk);
      if (outReady) void'(model.pop_front());
    end
    outReady = 1'b0; sampleEn = 1'b0; errFlag = 1'b0; rearm = 1'b0;
    chk(outValid == 1'b0, "R8 valid drops after newest", int'(outValid), 0);
    chk(frozen == 1'b1, "R10 still frozen after readout", int'(frozen), 1);
  endtask

  task automatic doRearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    model.delete();
    chk(frozen == 1'b0, "R10 rearm resumes capture", int'(frozen), 0);
    chk(outValid == 1'b0, "R10 rearm no output", int'(outValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    chk(frozen == 1'b0, "R1 reset frozen", int'(frozen), 0);
    chk(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(frozen == 1'b0 && outValid == 1'b0 && outLast == 1'b0, "R1 after reset", int'(frozen), 0);

    // Short history, no wrap
    capture(12, 70, 1'b1);
    drain("R4 short", 1'b0);
    doRearm();

    // Single record: error on the only sample
    capture(1, 0, 1'b1);
    drain("R3 single", 1'b0);
    doRearm();

    // Exactly DEPTH records
    capture(DEPTH, 100, 1'b1);
    drain("R5 full", 1'b0);
    doRearm();

    // DEPTH plus one
    capture(DEPTH + 1, 100, 1'b1);
    drain("R5 one past full", 1'b1);   // rearm on final handshake is ignored (R10)
    doRearm();

    // Error with empty store and no sample
    @(negedge clk);
    errFlag = 1'b1;
    @(negedge clk);
    errFlag = 1'b0;
    chk(frozen == 1'b1, "R11 frozen on empty", int'(frozen), 1);
    chk(outValid == 1'b0, "R11 no readout", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b0, "R11 still no readout", int'(outValid), 0);
    doRearm();

    // Random histories, many wrapping
    for (int k = 0; k < 12; k++) begin
      capture(1 + int'($urandom % 150), 20 + int'($urandom % 80), 1'b1);
      drain("R5 random", k[0]);
      doRearm();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule